// File: doc/BRIEF.md
# Programmable divide-by-N counter

This block divides its input clock by a ratio N taken from a 16-bit parallel preset word. It is a synchronous down-counter split into three parts. A fast first section has a selectable modulus M of 2, 4, 5, 8 or 10. Three cascaded decades follow it, and a small high-order last section uses whichever of the four low preset bits the first section does not need. Whenever the whole count reaches its terminal state, the block reloads the preset word and emits a one-clock output pulse. A frequency synthesizer uses it as the programmable feedback divider. The first-section modulus sets the channel spacing, and the preset word picks the channel.

A three-bit selector picks the first-section modulus. Two of its patterns instead select a hold state. In hold, every counter flop loads from the preset word and stays there. Leaving hold costs one enabling clock edge before counting starts. A synchronous reset behaves exactly like the hold state. Each decade accepts preset values from 10 to 15, which widens the usable range of N.

Top module: `prog_divn`

## Requirements
- R1: The selector `div_sel` = {s2,s1,s0} decodes as follows: 111 gives M=2, 001 gives M=4, 011 gives M=5, 101 gives M=8, and 110 and 010 give M=10. Any pattern with s1=s0=0 is hold.
- R2: In a counting mode, the low preset nibble `preset[3:0]` splits into a first-section value f, taken from its low b bits, and a last-section value L, taken from the bits above them. b is 1 for M=2, 2 for M=4, 3 for M=5 and M=8, and 4 for M=10, where no last section exists. The decade digits are d2=`preset[7:4]`, d3=`preset[11:8]` and d4=`preset[15:12]`. Consecutive output pulses are N = M·(1000·L + 100·d4 + 10·d3 + d2) + f clock cycles apart. For example, M=5 with preset 16'h695C gives N=8479.
- R3: `pulse_out` is a registered signal that is high for one clock period. It rises on the clock edge that reloads the counter and is low on every other edge.
- R4: While hold is selected, all counter flops follow the preset word on every edge and `pulse_out` stays low.
- R5: After hold ends, the first rising edge only enables counting. The first pulse therefore appears N+1 edges after release, and later pulses follow every N edges.
- R6: A decade preset to a value from 10 to 15 counts that many steps on its first pass and 10 steps on later passes. For example, M=8 with preset 16'hFFFF gives N=21327.
- R7: A preset giving N=0 or N=1 makes `pulse_out` high on every clock once counting has started.
- R8: A change to `preset` while counting has no effect until the next reload. The period that is already running keeps its old length, and the reload loads the new word.
- R9: The synchronous active-high `rst` acts as hold. It loads the preset word, keeps `pulse_out` low, and is followed by the same one-edge enable delay.
- R10: The last section counts with weight 1000·M. In M=2 mode it holds values up to 7. For example, preset 16'h000F gives N=14001.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counting clock |
| rst | input | 1 | Synchronous active-high reset, behaves as hold |
| div_sel | input | 3 | First-section modulus select / hold request |
| preset | input | 16 | Preset word: low nibble for first and last sections, then d2, d3, d4 |
| pulse_out | output | 1 | One-clock pulse each time the count reloads |

## Verification
The assertions assume that `rst` is high from time zero, so that every `$past` value they read comes from a defined cycle. They also assume that `div_sel` moves only between hold and a counting mode, never directly from one counting mode to another in the middle of a period. The stimulus follows both assumptions. It enters hold, or raises `rst`, for three edges before every new ratio. It changes `preset` during counting only right after a reload edge. A run of hold cycles with a changing preset word checks that the output stays quiet.

// File: rtl/prog_divn_pkg.sv
package prog_divn_pkg;

   typedef enum logic [2:0] {
      FS_DIV2,
      FS_DIV4,
      FS_DIV5,
      FS_DIV8,
      FS_DIV10,
      FS_HOLD
   } fs_kind_e;

   typedef struct packed {
      logic       hold;
      logic [3:0] wrap;   // M-1, value the first section takes after zero
      logic [3:0] fmask;  // bits of the low nibble owned by the first section
   } fs_cfg_t;

   function automatic fs_kind_e fs_kind(input logic [2:0] sel);
      fs_kind_e k;
      if (sel[1:0] == 2'b00) k = FS_HOLD;
      else begin
         case (sel)
            3'b111:  k = FS_DIV2;
            3'b001:  k = FS_DIV4;
            3'b011:  k = FS_DIV5;
            3'b101:  k = FS_DIV8;
            default: k = FS_DIV10;
         endcase
      end
      return k;
   endfunction

   function automatic fs_cfg_t fs_cfg(input fs_kind_e k);
      fs_cfg_t c;
      c.hold = 1'b0;
      case (k)
         FS_DIV2:  begin c.wrap = 4'd1; c.fmask = 4'b0001; end
         FS_DIV4:  begin c.wrap = 4'd3; c.fmask = 4'b0011; end
         FS_DIV5:  begin c.wrap = 4'd4; c.fmask = 4'b0111; end
         FS_DIV8:  begin c.wrap = 4'd7; c.fmask = 4'b0111; end
         FS_DIV10: begin c.wrap = 4'd9; c.fmask = 4'b1111; end
         default:  begin c.wrap = 4'd9; c.fmask = 4'b1111; c.hold = 1'b1; end
      endcase
      return c;
   endfunction

endpackage

// File: rtl/prog_divn_mode_dec.sv
module prog_divn_mode_dec
   import prog_divn_pkg::*;
(
   input  logic [2:0] div_sel,
   output logic       hold_mode,
   output logic [3:0] wrap_val,
   output logic [3:0] fmask
);
   fs_cfg_t cfg;

   always_comb begin
      cfg       = fs_cfg(fs_kind(div_sel));
      hold_mode = cfg.hold;
      wrap_val  = cfg.wrap;
      fmask     = cfg.fmask;
   end
endmodule

// File: rtl/prog_divn_low.sv
// Low nibble: first section in the masked bits, last section above them.
module prog_divn_low #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         load,
   input  logic         step,
   input  logic [W-1:0] load_val,
   input  logic [W-1:0] fmask,
   input  logic [W-1:0] wrap_val,
   input  logic         top_borrow,
   output logic         f_zero,
   output logic         f_le1,
   output logic         last_zero,
   output logic [W-1:0] q
);
   logic [W-1:0] f_cur, hi_cur, f_nx, hi_nx, lsb_w;

   always_comb begin
      f_cur     = q & fmask;
      hi_cur    = q & ~fmask;
      f_zero    = (f_cur == '0);
      f_le1     = (f_cur <= W'(1));
      last_zero = (hi_cur == '0);
      lsb_w     = fmask + W'(1);
      f_nx      = f_zero ? wrap_val : f_cur - W'(1);
      hi_nx     = top_borrow ? hi_cur - lsb_w : hi_cur;
   end

   always_ff @(posedge clk) begin
      if (load)      q <= load_val;
      else if (step) q <= (hi_nx & ~fmask) | (f_nx & fmask);
   end
endmodule

// File: rtl/prog_divn_digit.sv
// One presettable down-counting digit; values above RADIX-1 drain once.
module prog_divn_digit #(
   parameter int DW    = 4,
   parameter int RADIX = 10
) (
   input  logic          clk,
   input  logic          load,
   input  logic          step,
   input  logic [DW-1:0] load_val,
   input  logic          bin,
   output logic          bout,
   output logic          zero,
   output logic [DW-1:0] q
);
   localparam logic [DW-1:0] TOP = DW'(RADIX - 1);

   assign zero = (q == '0);
   assign bout = bin & zero;

   always_ff @(posedge clk) begin
      if (load)             q <= load_val;
      else if (step && bin) q <= zero ? TOP : q - DW'(1);
   end
endmodule

// File: rtl/prog_divn.sv
module prog_divn
   import prog_divn_pkg::*;
#(
   parameter int NDEC  = 3,
   parameter int DW    = 4,
   parameter int RADIX = 10,
   parameter int LOW_W = 4
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic [2:0]                div_sel,
   input  logic [LOW_W+NDEC*DW-1:0]  preset,
   output logic                      pulse_out
);
   localparam int JAM_W = LOW_W + NDEC * DW;

   if (LOW_W != 4) begin : g_bad_low
      initial $fatal(1, "prog_divn: LOW_W must be 4");
   end
   if (NDEC < 1) begin : g_bad_ndec
      initial $fatal(1, "prog_divn: NDEC must be at least 1");
   end
   if (RADIX < 2 || RADIX > (1 << DW)) begin : g_bad_radix
      initial $fatal(1, "prog_divn: RADIX does not fit DW bits");
   end

   logic                     sel_hold, hold_all, fire, load_all, step_all;
   logic                     en_q, pulse_q;
   logic [3:0]               wrap_val, fmask;
   logic                     f_zero, f_le1, last_zero;
   logic [LOW_W-1:0]         lo_q;
   logic [NDEC:0]            borrow;
   logic [NDEC-1:0]          zero_v;
   logic [NDEC-1:0][DW-1:0]  dig_q;
   logic [JAM_W-1:0]         cnt_state;

   prog_divn_mode_dec u_dec (
      .div_sel   (div_sel),
      .hold_mode (sel_hold),
      .wrap_val  (wrap_val),
      .fmask     (fmask)
   );

   prog_divn_low #(.W(LOW_W)) u_low (
      .clk        (clk),
      .load       (load_all),
      .step       (step_all),
      .load_val   (preset[LOW_W-1:0]),
      .fmask      (fmask),
      .wrap_val   (wrap_val),
      .top_borrow (borrow[NDEC]),
      .f_zero     (f_zero),
      .f_le1      (f_le1),
      .last_zero  (last_zero),
      .q          (lo_q)
   );

   assign borrow[0] = f_zero;

   for (genvar i = 0; i < NDEC; i++) begin : g_dig
      prog_divn_digit #(.DW(DW), .RADIX(RADIX)) u_d (
         .clk      (clk),
         .load     (load_all),
         .step     (step_all),
         .load_val (preset[LOW_W + i*DW +: DW]),
         .bin      (borrow[i]),
         .bout     (borrow[i+1]),
         .zero     (zero_v[i]),
         .q        (dig_q[i])
      );
   end

   assign hold_all  = rst | sel_hold;
   assign fire      = en_q & ~hold_all & (&zero_v) & last_zero & f_le1;
   assign load_all  = hold_all | fire;
   assign step_all  = en_q & ~hold_all & ~fire;
   assign cnt_state = {dig_q, lo_q};

   always_ff @(posedge clk) begin
      en_q    <= ~hold_all;
      pulse_q <= fire;
   end

   assign pulse_out = pulse_q;
endmodule

// File: rtl/prog_divn_chk.sv
module prog_divn_chk #(
   parameter int W = 16
) (
   input logic         clk,
   input logic         rst,
   input logic [2:0]   div_sel,
   input logic [W-1:0] preset,
   input logic         pulse_out,
   input logic [W-1:0] state_q
);
   // R4: hold keeps the output low
   a_r4_hold_quiet: assert property (@(posedge clk) disable iff (rst)
      (div_sel[1:0] == 2'b00) |=> !pulse_out);

   // R4: hold copies the preset word into the counter
   a_r4_hold_loads: assert property (@(posedge clk) disable iff (rst)
      (div_sel[1:0] == 2'b00) |=> (state_q == $past(preset)));

   // R5: the edge after the last hold edge only enables, no pulse yet
   a_r5_release_gap: assert property (@(posedge clk) disable iff (rst)
      (div_sel[1:0] == 2'b00) |-> ##2 !pulse_out);

   // R8: a pulse coincides with a fresh load of the preset word
   a_r8_reload_jam: assert property (@(posedge clk) disable iff (rst)
      pulse_out |-> (state_q == $past(preset)));
endmodule

bind prog_divn prog_divn_chk #(.W(LOW_W + NDEC*DW)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .div_sel   (div_sel),
   .preset    (preset),
   .pulse_out (pulse_out),
   .state_q   (cnt_state)
);

// File: tb/sim_prog_divn.sv
module sim_prog_divn;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [2:0]  sel = 3'b000;
   logic [15:0] jam = 16'h0000;
   logic        pulse;

   int    cyc = 0;
   int    nchk = 0;
   int    nfail = 0;
   bit    mon_on = 1'b0;
   string cur_tag = "R9 reset state";
   int    exp_q[$];

   prog_divn u0 (
      .clk       (clk),
      .rst       (rst),
      .div_sel   (sel),
      .preset    (jam),
      .pulse_out (pulse)
   );

   always #10 clk = ~clk;

   always @(posedge clk) cyc = cyc + 1;

   // monitor: compares the pulse against the scoreboard each cycle (R3)
   always @(negedge clk) begin
      if (mon_on) begin
         bit e;
         e = (exp_q.size() > 0) && (exp_q[0] == cyc);
         if (e) void'(exp_q.pop_front());
         nchk++;
         if (pulse !== e) begin
            nfail++;
            $display("FAIL %s cycle %0d pulse=%b expected %b", cur_tag, cyc, pulse, e);
         end
      end
   end

   // ratio from R1, R2, R10: field split by mode, weighted sum
   function automatic int ratio(input logic [2:0] s, input logic [15:0] j);
      int m, fb, f, l, n;
      case (s)
         3'b111:  begin m = 2;  fb = 1; end
         3'b001:  begin m = 4;  fb = 2; end
         3'b011:  begin m = 5;  fb = 3; end
         3'b101:  begin m = 8;  fb = 3; end
         default: begin m = 10; fb = 4; end
      endcase
      f = int'(j[3:0]) & ((1 << fb) - 1);
      l = int'(j[3:0]) >> fb;
      n = m * (1000 * l + 100 * int'(j[15:12]) + 10 * int'(j[11:8]) + int'(j[7:4])) + f;
      return (n < 1) ? 1 : n;
   endfunction

   // driver: hold (or reset) three edges, release, queue expected pulses (R5)
   task automatic run_case(input string tag, input logic [2:0] s, input logic [15:0] j,
                           input int npulse, input bit via_rst,
                           input bit do_sw, input logic [15:0] j2);
      int k, n1, n2, p, p1;
      cur_tag = tag;
      jam = j;
      if (via_rst) begin rst = 1'b1; sel = s; end
      else sel = 3'b000;
      repeat (3) @(negedge clk);
      k   = cyc;
      rst = 1'b0;
      sel = s;
      n1  = ratio(s, j);
      n2  = do_sw ? ratio(s, j2) : n1;
      p   = k + n1 + 1;
      p1  = p;
      exp_q.push_back(p);
      for (int i = 2; i <= npulse; i++) begin
         p = p + ((i == 2) ? n1 : n2);
         exp_q.push_back(p);
      end
      if (do_sw) begin
         while (cyc < p1) @(negedge clk);
         jam = j2;   // R8: applied right after a reload
      end
      while (cyc < p) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      mon_on = 1'b1;                       // R9: output low under reset
      repeat (2) @(negedge clk);
      run_case("R2 div10 N=35",         3'b110, 16'h0035, 3, 1'b0, 1'b0, 16'h0);
      run_case("R2 div5 N=8479",        3'b011, 16'h695C, 2, 1'b0, 1'b0, 16'h0);
      run_case("R10 div2 last=7",       3'b111, 16'h000F, 2, 1'b0, 1'b0, 16'h0);
      run_case("R1 div4 N=4050",        3'b001, 16'h0126, 2, 1'b0, 1'b0, 16'h0);
      run_case("R1 div8 N=35",          3'b101, 16'h0043, 3, 1'b0, 1'b0, 16'h0);
      run_case("R1 sel010 as div10",    3'b010, 16'h0017, 3, 1'b0, 1'b0, 16'h0);
      run_case("R6 div8 max 21327",     3'b101, 16'hFFFF, 2, 1'b0, 1'b0, 16'h0);
      run_case("R6 decade preset 12",   3'b110, 16'h00C3, 3, 1'b0, 1'b0, 16'h0);
      run_case("R7 N=0 every clock",    3'b110, 16'h0000, 6, 1'b0, 1'b0, 16'h0);
      run_case("R7 N=1 every clock",    3'b111, 16'h0001, 6, 1'b0, 1'b0, 16'h0);
      run_case("R9 reset as hold",      3'b011, 16'h0027, 3, 1'b1, 1'b0, 16'h0);
      run_case("R8 preset change",      3'b110, 16'h0012, 4, 1'b0, 1'b1, 16'h0005);
      cur_tag = "R4 hold quiet";
      sel = 3'b100;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         jam = jam ^ 16'h1357;
      end
      run_case("R5 release after hold", 3'b101, 16'h0021, 2, 1'b0, 1'b0, 16'h0);
      @(negedge clk);
      if (exp_q.size() != 0) begin
         nfail++;
         $display("FAIL R3 %0d expected pulses never seen, expected 0", exp_q.size());
      end
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog: cycle %0d reached, expected completion earlier", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end
endmodule